// File: doc/BRIEF.md
# Digital Frequency Offset Compensator

This block takes the signed frequency-error value that a discriminator produces once per measurement cycle and turns it into a held offset. It then applies that offset to a 12-bit synthesizer frequency word. How the offset register is loaded depends on a 2-bit policy field. The first policy is a manual mode, where a strobe edge copies the latest result. The other three are automatic: capture once after power-up, track only while valid data is present, and keep the last capture. Each loaded value is first limited to one of four selectable ranges.

An automatic load happens only when both of these hold: the valid-data indicator stayed high on every clock of the measurement cycle, and the result of that cycle equals the result of the cycle before it. A fine setting stretches each measurement cycle to two measurement pulses. Status outputs give the held offset, a bit that flips at every cycle end, and a flag that shows two matching results in a row.

Top module: `freq_offset_comp`

## Requirements
- R1: After reset is released, `offset_o` is 0, `toggle_o` is 0 and `same_o` is 0. `fword_o` equals `fword_i`, or equals it plus a zero offset.
- R2: A measurement pulse counts only when `meas_vld_i` and `calc_en_i` are both high on a clock edge. Pulses that do not count change no output. A measurement cycle ends at a counted pulse, and `toggle_o` inverts at every cycle end.
- R3: When `fine_i` is 1, a cycle ends only on every second counted pulse, and the result is the value presented on that second pulse. When `fine_i` is 0, every counted pulse ends a cycle. The pulse phase returns to "first" whenever `fine_i` is 0.
- R4: At each cycle end, `same_o` becomes 1 when the new result equals the previous result, and 0 otherwise. It is always 0 at the first cycle end after reset. It holds its value between cycle ends.
- R5: A value is limited before it is stored. `range_i` 00 stores it unchanged. 01 limits it to -16..15, 10 to -8..7, and 11 to -4..3.
- R6: With `mode_i`=00, the offset changes only on a clock where `strobe_i` is 1 after having been 0 on the previous clock. On that clock it loads the limited value of the most recent result from before that clock.
- R7: An automatic load needs a qualifying cycle end. The cycle end must have a result equal to the previous one. `vdi_i` must also have been 1 on every clock from the clock after the previous cycle end up to and including this one. The first cycle after reset never qualifies.
- R8: With `mode_i`=01, the first qualifying cycle end after reset loads the offset. Later qualifying cycle ends are ignored until the next reset.
- R9: With `mode_i`=10, a clock edge on which `vdi_i` is 0 clears the offset to 0. Otherwise a qualifying cycle end loads it.
- R10: With `mode_i`=11, every qualifying cycle end loads the offset, and `vdi_i` going low does not clear it.
- R11: With `out_en_i`=1, `fword_o` is `fword_i` plus the sign-extended offset, limited to 0..4095. With `out_en_i`=0, `fword_o` equals `fword_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| meas_i | input | 7 | Signed measured frequency error |
| meas_vld_i | input | 1 | One-clock pulse marking a new measurement |
| vdi_i | input | 1 | Valid-data indicator |
| strobe_i | input | 1 | Manual load strobe (rising edge) |
| mode_i | input | 2 | Load policy: 00 manual, 01 once, 10 while valid, 11 keep |
| range_i | input | 2 | Limit select |
| calc_en_i | input | 1 | Accept measurements |
| out_en_i | input | 1 | Apply offset to frequency word |
| fine_i | input | 1 | Two pulses per measurement cycle |
| fword_i | input | 12 | Uncorrected frequency word |
| fword_o | output | 12 | Corrected frequency word |
| offset_o | output | 7 | Held signed offset |
| toggle_o | output | 1 | Inverts at every cycle end |
| same_o | output | 1 | Last two results matched |

## Verification
The hardest situation to reach is an automatic load. It needs two equal 7-bit results in a row, with the valid-data indicator unbroken since the previous cycle end. Uniform random values almost never repeat. The stimulus therefore draws measurements from a small pool that includes the extremes -64 and 63, and keeps valid data high most of the time. Directed sequences drive the once-only, clear-on-invalid, manual-strobe, fine-mode and output-saturation cases to known values.

// File: rtl/freq_offset_comp.sv
module freq_offset_comp #(
  parameter int FW = 12,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] meas_i,
  input  logic          meas_vld_i,
  input  logic          vdi_i,
  input  logic          strobe_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    range_i,
  input  logic          calc_en_i,
  input  logic          out_en_i,
  input  logic          fine_i,
  input  logic [FW-1:0] fword_i,
  output logic [FW-1:0] fword_o,
  output logic [MW-1:0] offset_o,
  output logic          toggle_o,
  output logic          same_o
);
  localparam int SW = FW + 2;
  localparam logic signed [SW-1:0] WMAX = SW'((1 << FW) - 1);

  logic [MW-1:0] last_q, off_q;
  logic phase_q, have_q, vrun_q, once_q, stb_q, tog_q, same_q;

  function automatic logic [MW-1:0] limit(input logic [MW-1:0] v, input logic [1:0] r);
    logic signed [MW-1:0] s, hi, lo;
    s = $signed(v);
    case (r)
      2'b01:   begin hi = MW'(15); lo = -MW'(16); end
      2'b10:   begin hi = MW'(7);  lo = -MW'(8);  end
      2'b11:   begin hi = MW'(3);  lo = -MW'(4);  end
      default: begin hi = {1'b0, {(MW-1){1'b1}}}; lo = {1'b1, {(MW-1){1'b0}}}; end
    endcase
    if (s > hi) return hi;
    if (s < lo) return lo;
    return v;
  endfunction

  wire take    = meas_vld_i & calc_en_i;
  wire cyc_end = take & (~fine_i | phase_q);
  wire match   = have_q & (meas_i == last_q);
  wire auto_ok = cyc_end & vrun_q & vdi_i & match;
  wire stb_up  = strobe_i & ~stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0; off_q <= '0; phase_q <= 1'b0; have_q <= 1'b0;
      vrun_q <= 1'b0; once_q <= 1'b0; stb_q <= 1'b0; tog_q <= 1'b0; same_q <= 1'b0;
    end else begin
      stb_q   <= strobe_i;
      phase_q <= fine_i & (phase_q ^ take);
      if (cyc_end) begin
        tog_q  <= ~tog_q;
        same_q <= match;
        have_q <= 1'b1;
        last_q <= meas_i;
        vrun_q <= 1'b1;
      end else begin
        vrun_q <= vrun_q & vdi_i;
      end
      case (mode_i)
        2'b00: if (stb_up) off_q <= limit(last_q, range_i);
        2'b01: if (auto_ok && !once_q) begin
                 off_q  <= limit(meas_i, range_i);
                 once_q <= 1'b1;
               end
        2'b10: if (!vdi_i) off_q <= '0;
               else if (auto_ok) off_q <= limit(meas_i, range_i);
        default: if (auto_ok) off_q <= limit(meas_i, range_i);
      endcase
    end
  end

  wire signed [SW-1:0] sum = $signed({2'b00, fword_i}) + SW'($signed(off_q));

  assign fword_o  = !out_en_i ? fword_i :
                    (sum < 0) ? '0 :
                    (sum > WMAX) ? FW'(WMAX) : sum[FW-1:0];
  assign offset_o = off_q;
  assign toggle_o = tog_q;
  assign same_o   = same_q;
endmodule

module freq_offset_comp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        meas_vld_i,
  input logic        calc_en_i,
  input logic        vdi_i,
  input logic        strobe_i,
  input logic [1:0]  mode_i,
  input logic [1:0]  range_i,
  input logic        out_en_i,
  input logic [11:0] fword_i,
  input logic [11:0] fword_o,
  input logic [6:0]  offset_o,
  input logic        toggle_o
);
  assert_ignored_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_vld_i && calc_en_i) |=> $stable(toggle_o));

  assert_manual_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !strobe_i) |=> $stable(offset_o));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !vdi_i) |=> (offset_o == 7'd0));

  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !meas_vld_i) |=> $stable(offset_o));

  assert_narrow_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (range_i == 2'b11 && mode_i != 2'b00 && meas_vld_i) |=>
      ($stable(offset_o) || ($signed(offset_o) <= 3 && $signed(offset_o) >= -4)));

  assert_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |-> (fword_o == fword_i));
endmodule

bind freq_offset_comp freq_offset_comp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .meas_vld_i(meas_vld_i), .calc_en_i(calc_en_i),
  .vdi_i(vdi_i), .strobe_i(strobe_i), .mode_i(mode_i), .range_i(range_i),
  .out_en_i(out_en_i), .fword_i(fword_i), .fword_o(fword_o),
  .offset_o(offset_o), .toggle_o(toggle_o)
);

// File: tb/tb_freq_offset_comp.sv
module tb_freq_offset_comp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] meas_i = '0;
  logic meas_vld_i = 0, vdi_i = 0, strobe_i = 0, calc_en_i = 0, out_en_i = 0, fine_i = 0;
  logic [1:0] mode_i = '0, range_i = '0;
  logic [11:0] fword_i = '0;
  logic [11:0] fword_o;
  logic [6:0] offset_o;
  logic toggle_o, same_o;
  int total = 0, bad = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  freq_offset_comp dut (.*);

  // reference state
  logic [6:0] r_last, r_off;
  logic r_phase, r_have, r_vrun, r_once, r_stb, r_tog, r_same;

  function automatic logic [6:0] lim(input logic [6:0] v, input logic [1:0] r);
    int s, hi, lo;
    s = $signed(v);
    hi = (r == 1) ? 15 : (r == 2) ? 7 : (r == 3) ? 3 : 63;
    lo = (r == 1) ? -16 : (r == 2) ? -8 : (r == 3) ? -4 : -64;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return 7'(s);
  endfunction

  function automatic logic [11:0] expw(input logic [11:0] w, input logic [6:0] o, input logic en);
    int s;
    if (!en) return w;
    s = int'(w) + int'($signed(o));
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return 12'(s);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_last = 0; r_off = 0; r_phase = 0; r_have = 0; r_vrun = 0;
      r_once = 0; r_stb = 0; r_tog = 0; r_same = 0;
    end else begin
      logic acc, fin, eq, ok, rise;
      acc = meas_vld_i && calc_en_i;
      fin = acc && (!fine_i || r_phase);
      eq = r_have && (meas_i == r_last);
      ok = fin && eq && r_vrun && vdi_i;
      rise = strobe_i && !r_stb;
      if (mode_i == 0 && rise) r_off = lim(r_last, range_i);
      else if (mode_i == 1 && ok && !r_once) begin r_off = lim(meas_i, range_i); r_once = 1; end
      else if (mode_i == 2 && !vdi_i) r_off = 0;
      else if (mode_i >= 2 && ok) r_off = lim(meas_i, range_i);
      r_stb = strobe_i;
      r_phase = fine_i ? (acc ? !r_phase : r_phase) : 0;
      if (fin) begin
        r_tog = !r_tog; r_same = eq; r_have = 1; r_last = meas_i; r_vrun = 1;
      end else r_vrun = r_vrun && vdi_i;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R11 fword", fword_o, expw(fword_i, r_off, out_en_i));
    chk("R5/R6/R7 offset", offset_o, r_off);
    chk("R2/R3 toggle", toggle_o, r_tog);
    chk("R4 same", same_o, r_same);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); cmp_all();
  endtask

  task automatic pulse(input int v);
    meas_i = 7'(v); meas_vld_i = 1; tick(); meas_vld_i = 0; tick(); tick();
  endtask

  localparam int POOL [6] = '{5, -3, 63, -64, 0, 17};

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0;
    fword_i = 12'd1000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 offset", offset_o, 0);
    chk("R1 toggle", toggle_o, 0);
    chk("R1 same", same_o, 0);
    chk("R1 fword", fword_o, 1000);

    // R8 once-only capture
    calc_en_i = 1; vdi_i = 1; mode_i = 2'b01; out_en_i = 1;
    pulse(5); pulse(5);
    chk("R8 first load", offset_o, 5);
    chk("R4 equal results", same_o, 1);
    chk("R11 applied", fword_o, 1005);
    pulse(9); pulse(9);
    chk("R8 later ignored", offset_o, 5);

    // R9 track while valid, R5 limit
    mode_i = 2'b10; range_i = 2'b01;
    pulse(20); pulse(20);
    chk("R5 limit 15", offset_o, 15);
    vdi_i = 0; tick(); vdi_i = 1;
    chk("R9 cleared", offset_o, 0);
    // R7 broken valid data blocks load
    pulse(20); vdi_i = 0; tick(); vdi_i = 1; mode_i = 2'b11; pulse(20);
    chk("R7 no load after gap", offset_o, 0);
    pulse(20);
    chk("R10 load", offset_o, 15);
    vdi_i = 0; tick(); tick(); vdi_i = 1;
    chk("R10 kept", offset_o, 15);

    // R6 manual strobe
    mode_i = 2'b00; range_i = 2'b11;
    pulse(-30);
    chk("R6 no strobe yet", offset_o, 15);
    strobe_i = 1; tick();
    chk("R6 strobe load", $signed(offset_o), -4);
    fword_i = 12'd2; tick();
    chk("R11 floor", fword_o, 0);
    strobe_i = 0; range_i = 2'b00; pulse(63);
    strobe_i = 1; tick(); strobe_i = 0;
    fword_i = 12'd4090; tick();
    chk("R11 ceiling", fword_o, 4095);
    out_en_i = 0; tick();
    chk("R11 bypass", fword_o, 4090);

    // R2 gated pulses, R3 fine mode
    t0 = toggle_o;
    calc_en_i = 0; pulse(1);
    chk("R2 gated", toggle_o, t0);
    calc_en_i = 1; fine_i = 1;
    pulse(2);
    chk("R3 first of pair", toggle_o, t0);
    pulse(3);
    chk("R3 second of pair", toggle_o, !t0);
    fine_i = 0;

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      meas_vld_i = ($urandom % 4) == 0;
      meas_i = 7'(POOL[$urandom % 6]);
      vdi_i = ($urandom % 16) != 0;
      strobe_i = ($urandom % 8) == 0;
      calc_en_i = ($urandom % 10) != 0;
      out_en_i = ($urandom % 4) != 0;
      if ($urandom % 200 == 0) fine_i = $urandom;
      if ($urandom % 150 == 0) mode_i = 2'($urandom);
      if ($urandom % 100 == 0) range_i = 2'($urandom);
      case ($urandom % 4)
        0: fword_i = 12'($urandom % 40);
        1: fword_i = 12'(4095 - $urandom % 40);
        default: fword_i = 12'($urandom);
      endcase
      tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule